// File: doc/BRIEF.md
# Flash command interface controller

This block is the command front end of a block-erasable flash memory model. Each bus write cycle carries a command code on the low byte of the data bus. The controller decodes these codes and tracks whether reads return array contents or the status register. It runs a two-cycle block erase handshake, lets a running erase be paused and resumed, and keeps sticky error flags until software clears them on purpose.

The memory is a small array of words split into equal blocks. Erase time is a fixed number of clock cycles counted inside the block. Two inputs gate erasing: a programming-voltage-valid flag and an active-low write-protect pin, which guards block 0.

The status byte has this layout:

| Bit | Meaning |
|-----|---------|
| 7 | Ready |
| 6 | Erase suspended |
| 5 | Erase error |
| 4 | Sequence/write error |
| 3 | Voltage error |
| 2:0 | Always 0 |

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, status is 80h and reads return array data. Word i of the array holds the value {i[7:0] XOR 5Ah, i[7:0]} (high byte, low byte).
- R2: A write of 20h followed directly by a write of D0h starts an erase of the block given by the address of the D0h cycle. The address of the 20h cycle is ignored. ERASE_CYCLES clocks later, every word of that block reads FFFFh, and reads return status with bit 7 set.
- R3: If the write after 20h carries any code other than D0h, bits 4 and 5 are set, nothing is erased, and reads return status.
- R4: While an erase runs, every read returns {00h, status} with bit 7 at 0, whatever the read mode and the address.
- R5: While an erase runs, B0h suspends it on the next clock. Bits 6 and 7 then read 1, and the remaining erase count is held.
- R6: While suspended, only three codes act. FFh selects array reads, and addresses inside the block being erased still return status. 70h selects status reads. D0h resumes the erase with the held count. All other codes, 50h included, have no effect.
- R7: D0h and any code other than B0h, written while an erase runs, have no effect. The erase finishes on its original schedule.
- R8: Bits 3 to 5 are only ever set by the controller. They survive later commands and completed erases, and only a 50h write in idle clears them. A 50h write leaves bits 6 and 7 alone.
- R9: If the voltage-valid input is low on the D0h cycle, bits 3 and 5 are set and nothing is erased. If bit 3 is already set, a confirm only sets bit 5 and nothing is erased.
- R10: A confirm aimed at block 0 while the write-protect input is low sets bit 5 and erases nothing. With the input high, block 0 erases normally.
- R11: In byte mode, any write whose low byte is FFh selects array reads. In word mode, only FFFFh does, and a word like 00FFh is a no-op. Unrecognised codes in idle keep the current read mode.
- R12: A 70h write selects status reads, which return {00h, status}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write cycle strobe, one command per cycle |
| wr_addr | input | ADDR_W | Address of the write cycle (selects the block on confirm) |
| wr_data | input | 16 | Command code on bits 7:0 (all 16 bits for word-mode null write) |
| byte_mode | input | 1 | 1 = byte bus mode, 0 = word bus mode |
| vpp_ok | input | 1 | Programming voltage valid |
| wp_n | input | 1 | Write protect for block 0, active low |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 16 | Array word or {00h, status} |

## Verification
The bench goes after these corner cases:
- A suspend followed by reads inside and outside the frozen block. A design that ignored the block boundary would leak half-erased data.
- A D0h sent while the erase is busy. A design that mistook it for a resume would restart the count or change state.
- Clear commands sent while suspended, and error flags that must outlive a finished erase. A design whose engine wiped its own flags would lose them.
- A voltage failure at confirm, then a retry while the voltage flag is still set. Both must leave the array untouched.
- Null writes in word mode. A design that checked only the low byte would accept 00FFh as read-array.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int DATA_W = 16;

    localparam logic [7:0] OP_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_RD_STATUS = 8'h70;
    localparam logic [7:0] OP_CLEAR     = 8'h50;
    localparam logic [7:0] OP_SETUP     = 8'h20;
    localparam logic [7:0] OP_CONFIRM   = 8'hD0;
    localparam logic [7:0] OP_SUSPEND   = 8'hB0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ERASE,
        ST_SUSP
    } st_e;

    typedef enum logic {
        RM_ARRAY,
        RM_STATUS
    } rmode_e;

    typedef enum logic [2:0] {
        CMD_RD_ARRAY,
        CMD_RD_STATUS,
        CMD_CLEAR,
        CMD_SETUP,
        CMD_CONFIRM,
        CMD_SUSPEND,
        CMD_OTHER
    } cmd_e;

    typedef struct packed {
        logic erase_err;   // status bit 5
        logic seq_err;     // status bit 4
        logic vpp_err;     // status bit 3
    } err_t;

    function automatic logic [DATA_W-1:0] init_word(input int unsigned idx);
        logic [7:0] lo;
        lo = 8'(idx);
        return {lo ^ 8'h5A, lo};
    endfunction

    function automatic logic [7:0] pack_status(input logic ready, input logic susp, input err_t e);
        return {ready, susp, e, 3'b000};
    endfunction

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [DATA_W-1:0] wr_data,
    input  logic              byte_mode,
    output cmd_e              cmd
);
    logic null_write;

    // A null write is all ones across the active bus width
    always_comb begin
        if (byte_mode) null_write = (wr_data[7:0] == OP_RD_ARRAY);
        else           null_write = (wr_data == {DATA_W{1'b1}});
    end

    always_comb begin
        if (null_write) begin
            cmd = CMD_RD_ARRAY;
        end else begin
            case (wr_data[7:0])
                OP_RD_STATUS: cmd = CMD_RD_STATUS;
                OP_CLEAR:     cmd = CMD_CLEAR;
                OP_SETUP:     cmd = CMD_SETUP;
                OP_CONFIRM:   cmd = CMD_CONFIRM;
                OP_SUSPEND:   cmd = CMD_SUSPEND;
                default:      cmd = CMD_OTHER;
            endcase
        end
    end
endmodule

// File: rtl/flash_erase_timer.sv
module flash_erase_timer #(
    parameter int ERASE_CYCLES = 12,
    localparam int CNT_W = $clog2(ERASE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic done
);
    logic [CNT_W-1:0] remain_q;

    assign done = run && (remain_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= CNT_W'(ERASE_CYCLES);
        end else if (run && remain_q != '0) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/flash_array_model.sv
module flash_array_model
    import flash_cmd_pkg::*;
#(
    parameter int NUM_BLOCKS  = 4,
    parameter int BLOCK_WORDS = 8,
    localparam int WORD_AW = $clog2(BLOCK_WORDS),
    localparam int BLK_W   = $clog2(NUM_BLOCKS),
    localparam int ADDR_W  = BLK_W + WORD_AW,
    localparam int NWORDS  = NUM_BLOCKS * BLOCK_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              erase_en,
    input  logic [BLK_W-1:0]  erase_blk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] mem [NWORDS];

    assign rd_word = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWORDS; i++) begin
                mem[i] <= init_word(i);
            end
        end else if (erase_en) begin
            for (int w = 0; w < BLOCK_WORDS; w++) begin
                mem[{erase_blk, WORD_AW'(w)}] <= {DATA_W{1'b1}};
            end
        end
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int NUM_BLOCKS   = 4,
    parameter int BLOCK_WORDS  = 8,
    parameter int ERASE_CYCLES = 12,
    parameter int PROT_BLOCK   = 0,
    localparam int WORD_AW = $clog2(BLOCK_WORDS),
    localparam int BLK_W   = $clog2(NUM_BLOCKS),
    localparam int ADDR_W  = BLK_W + WORD_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              byte_mode,
    input  logic              vpp_ok,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    st_e    st_q;
    rmode_e mode_q;
    err_t   err_q;
    logic [BLK_W-1:0] blk_q;
    cmd_e   cmd;
    logic   timer_load, timer_run, timer_done;
    logic [7:0] status;
    logic [DATA_W-1:0] arr_word;
    logic [BLK_W-1:0]  wr_blk, rd_blk;
    logic   confirm_ok, show_status;
    logic   unused_low_bits;

    assign wr_blk = wr_addr[ADDR_W-1:WORD_AW];
    assign rd_blk = rd_addr[ADDR_W-1:WORD_AW];
    assign unused_low_bits = ^wr_addr[WORD_AW-1:0];

    flash_cmd_decode u_dec (
        .wr_data   (wr_data),
        .byte_mode (byte_mode),
        .cmd       (cmd)
    );

    // Confirm is accepted only with good voltage, no standing voltage
    // error, and the target not protected
    assign confirm_ok = vpp_ok && !err_q.vpp_err &&
                        !(!wp_n && wr_blk == BLK_W'(PROT_BLOCK));

    assign timer_load = (st_q == ST_SETUP) && wr_en &&
                        (cmd == CMD_CONFIRM) && confirm_ok;
    assign timer_run  = (st_q == ST_ERASE) &&
                        !(wr_en && cmd == CMD_SUSPEND);

    flash_erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .load (timer_load),
        .run  (timer_run),
        .done (timer_done)
    );

    flash_array_model #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_WORDS(BLOCK_WORDS)) u_arr (
        .clk       (clk),
        .rst       (rst),
        .erase_en  (timer_done),
        .erase_blk (blk_q),
        .rd_addr   (rd_addr),
        .rd_word   (arr_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            mode_q <= RM_ARRAY;
            err_q  <= '0;
            blk_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (wr_en) begin
                        case (cmd)
                            CMD_RD_ARRAY:  mode_q <= RM_ARRAY;
                            CMD_RD_STATUS: mode_q <= RM_STATUS;
                            CMD_CLEAR:     err_q  <= '0;
                            CMD_SETUP: begin
                                st_q   <= ST_SETUP;
                                mode_q <= RM_STATUS;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_SETUP: begin
                    if (wr_en) begin
                        st_q   <= ST_IDLE;
                        mode_q <= RM_STATUS;
                        if (cmd != CMD_CONFIRM) begin
                            err_q.seq_err   <= 1'b1;
                            err_q.erase_err <= 1'b1;
                        end else if (!vpp_ok) begin
                            err_q.vpp_err   <= 1'b1;
                            err_q.erase_err <= 1'b1;
                        end else if (!confirm_ok) begin
                            err_q.erase_err <= 1'b1;
                        end else begin
                            st_q  <= ST_ERASE;
                            blk_q <= wr_blk;
                        end
                    end
                end
                ST_ERASE: begin
                    if (wr_en && cmd == CMD_SUSPEND) st_q <= ST_SUSP;
                    else if (timer_done)             st_q <= ST_IDLE;
                end
                ST_SUSP: begin
                    if (wr_en) begin
                        case (cmd)
                            CMD_RD_ARRAY:  mode_q <= RM_ARRAY;
                            CMD_RD_STATUS: mode_q <= RM_STATUS;
                            CMD_CONFIRM: begin
                                st_q   <= ST_ERASE;
                                mode_q <= RM_STATUS;
                            end
                            default: ;
                        endcase
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign status = pack_status(st_q != ST_ERASE, st_q == ST_SUSP, err_q);

    always_comb begin
        show_status = (st_q == ST_ERASE) || (mode_q == RM_STATUS) ||
                      ((st_q == ST_SUSP) && (rd_blk == blk_q));
        rd_data = show_status ? {8'h00, status} : arr_word;
    end
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
    import flash_cmd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              vpp_ok,
    input logic [DATA_W-1:0] rd_data,
    input st_e               st,
    input logic [7:0]        sr
);
    p_busy_status_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ERASE) |-> (rd_data[15:8] == 8'h00 && !rd_data[7] && rd_data[7:0] == sr));

    p_suspend_flags_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ERASE && wr_en && wr_data[7:0] == OP_SUSPEND) |=> (sr[7] && sr[6]));

    p_bad_confirm_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SETUP && wr_en && wr_data[7:0] != OP_CONFIRM) |=> (sr[5] && sr[4] && st == ST_IDLE));

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (|($past(sr[5:3]) & ~sr[5:3])) |-> ($past(wr_en) && $past(wr_data[7:0]) == OP_CLEAR));

    p_vpp_refuse_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SETUP && wr_en && wr_data[7:0] == OP_CONFIRM && !vpp_ok)
        |=> (sr[3] && sr[5] && st == ST_IDLE));
endmodule

bind flash_cmd_ctrl flash_cmd_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .vpp_ok  (vpp_ok),
    .rd_data (rd_data),
    .st      (st_q),
    .sr      (status)
);

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int BW = 8;
    localparam int NCYC = 12;
    localparam int NW = NB * BW;

    logic clk = 1'b0;
    logic rst;
    logic wr_en;
    logic [4:0] wr_addr;
    logic [15:0] wr_data;
    logic byte_mode;
    logic vpp_ok;
    logic wp_n;
    logic [4:0] rd_addr;
    logic [15:0] rd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_ctrl #(.NUM_BLOCKS(NB), .BLOCK_WORDS(BW), .ERASE_CYCLES(NCYC), .PROT_BLOCK(0)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .byte_mode(byte_mode), .vpp_ok(vpp_ok), .wp_n(wp_n),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int n_tests = 0;
    int n_fail = 0;
    string req = "R1";

    // Reference model state
    int  mem [NW];
    bit  m_setup, m_busy, m_susp, m_stat;
    bit  e3, e4, e5;
    int  m_left, m_blk;

    task automatic model_reset();
        for (int i = 0; i < NW; i++) mem[i] = ((i ^ 'h5A) << 8) | i;
        m_setup = 0; m_busy = 0; m_susp = 0; m_stat = 0;
        e3 = 0; e4 = 0; e5 = 0; m_left = 0; m_blk = 0;
    endtask

    task automatic model_step(bit we, logic [15:0] d, int wa);
        logic [7:0] c;
        bit ra;
        c = d[7:0];
        ra = byte_mode ? (c == 8'hFF) : (d == 16'hFFFF);
        if (m_busy) begin
            if (we && !ra && c == 8'hB0) begin
                m_busy = 0; m_susp = 1;
            end else begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    for (int k = 0; k < BW; k++) mem[m_blk*BW + k] = 'hFFFF;
                    m_busy = 0;
                end
            end
        end else if (m_susp) begin
            if (we) begin
                if (ra) m_stat = 0;
                else if (c == 8'h70) m_stat = 1;
                else if (c == 8'hD0) begin m_susp = 0; m_busy = 1; m_stat = 1; end
            end
        end else if (m_setup) begin
            if (we) begin
                m_setup = 0; m_stat = 1;
                if (ra || c != 8'hD0) begin e4 = 1; e5 = 1; end
                else if (!vpp_ok) begin e3 = 1; e5 = 1; end
                else if (e3) e5 = 1;
                else if (!wp_n && (wa / BW) == 0) e5 = 1;
                else begin m_busy = 1; m_left = NCYC; m_blk = wa / BW; end
            end
        end else if (we) begin
            if (ra) m_stat = 0;
            else if (c == 8'h70) m_stat = 1;
            else if (c == 8'h50) begin e3 = 0; e4 = 0; e5 = 0; end
            else if (c == 8'h20) begin m_setup = 1; m_stat = 1; end
        end
    endtask

    function automatic logic [15:0] model_read(int a);
        logic [7:0] s;
        s = {~m_busy, m_susp, e5, e4, e3, 3'b000};
        if (m_busy || m_stat || (m_susp && (a / BW) == m_blk)) return {8'h00, s};
        return 16'(mem[a]);
    endfunction

    task automatic check(logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s rd_data=%h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(bit we, logic [15:0] d, int wa, int ra);
        wr_en = we; wr_data = d; wr_addr = wa[4:0]; rd_addr = ra[4:0];
        @(posedge clk);
        model_step(we, d, wa);
        @(negedge clk);
        check(rd_data, model_read(ra));
    endtask

    task automatic cmd(logic [15:0] d, int wa = 0);
        cyc(1'b1, d, wa, 0);
    endtask

    task automatic rd(int a);
        cyc(1'b0, 16'h0000, 0, a);
    endtask

    task automatic sweep();
        for (int a = 0; a < NW; a++) rd(a);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        byte_mode = 1; vpp_ok = 1; wp_n = 1;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset contents and status
        req = "R1"; sweep();
        req = "R12"; cmd(16'h0070); rd(3);
        req = "R1"; check(rd_data, 16'h0080);

        // R2: erase block 2, setup address (block 3) ignored
        req = "R2"; cmd(16'h0020, 31); cmd(16'h00D0, 17);
        req = "R4"; for (int i = 0; i < NCYC + 2; i++) rd(i % NW);
        req = "R2"; check(rd_data, 16'h0080);
        cmd(16'h00FF); sweep();

        // R3: wrong second command
        req = "R3"; cmd(16'h0020); cmd(16'h0070, 8); rd(8);
        check(rd_data, 16'h00B0);
        cmd(16'h00FF); sweep();

        // R8: errors survive commands and a finished erase
        req = "R8"; cmd(16'h0070); cmd(16'h0033); rd(0);
        cmd(16'h0020); cmd(16'h00D0, 24);
        for (int i = 0; i < NCYC + 1; i++) rd(24);
        check(rd_data, 16'h00B0);
        cmd(16'h0050); rd(0); check(rd_data, 16'h0080);

        // R5/R6: suspend and resume
        req = "R5"; cmd(16'h0020); cmd(16'h00D0, 9);
        rd(1); rd(2); rd(3); rd(4);
        cmd(16'h00B0); rd(9); check(rd_data, 16'h00C0);
        req = "R6"; cmd(16'h00FF);
        sweep();
        cmd(16'h0050); cmd(16'h0020); cmd(16'h0033); rd(0);
        cmd(16'h0070); rd(20);
        cmd(16'h00D0);
        for (int i = 0; i < NCYC; i++) rd(i);
        check(rd_data, 16'h0080);
        cmd(16'h00FF); sweep();

        // R7: confirm and other codes while busy are ignored
        req = "R7"; cmd(16'h0020); cmd(16'h00D0, 26);
        rd(0); cmd(16'h00D0); cmd(16'h0070); cmd(16'h0020); cmd(16'h00FF); cmd(16'h0050);
        for (int i = 0; i < NCYC; i++) rd(26);
        cmd(16'h00FF); sweep();

        // R9: voltage invalid at confirm, then retry while voltage error stands
        req = "R9"; cmd(16'h0020); vpp_ok = 0; cmd(16'h00D0, 5); vpp_ok = 1;
        rd(5); check(rd_data, 16'h00A8);
        cmd(16'h0020); cmd(16'h00D0, 5); rd(5); check(rd_data, 16'h00A8);
        cmd(16'h00FF); sweep();
        cmd(16'h0050);

        // R10: write protect on block 0
        req = "R10"; wp_n = 0; cmd(16'h0020); cmd(16'h00D0, 2); rd(2);
        check(rd_data, 16'h00A0);
        cmd(16'h0050); cmd(16'h00FF); sweep();
        wp_n = 1; cmd(16'h0020); cmd(16'h00D0, 2);
        for (int i = 0; i < NCYC; i++) rd(2);
        cmd(16'h00FF); sweep();

        // R11: null write width and unknown codes
        req = "R11"; cmd(16'h0070); cmd(16'h12FF); rd(1);
        cmd(16'h0070); byte_mode = 0; cmd(16'h00FF); rd(1);
        check(rd_data, 16'h0080);
        cmd(16'hFFFF); rd(1); cmd(16'h0044); rd(7);
        cmd(16'h0070); cmd(16'h0044); rd(7);
        byte_mode = 1;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule